// File: doc/BRIEF.md
# Link Calibration and Output Gating Controller

This controller sits in one channel of a serial repeater. Each clock it looks at the sampled line bit and decides what the channel sends onward. A fresh channel is uncalibrated. The first transition after that starts a calibration window of fixed length. The window is needed after power-up, after an idle timeout and after the input side loses power. While the channel is not calibrated the repeated bit is forced high. Once calibrated, the repeated bit follows the sampled input in the same cycle.

The controller counts cycles since the last transition. If the line stays quiet for too long, the channel drops back to the uncalibrated state. When the input side reports its supply down, the output takes its default high level at once and calibration is lost. A separate output-enable input controls the tri-state drive flag. The controller also reports runs of equal bits that exceed the allowed length while calibrated.

Top module: `link_cal_gate`

## Requirements
- R1: With synchronous reset `rst` high, the channel is uncalibrated (`calibrated`=0), `txBit`=1, `calDone`=0 and `runViolation`=0.
- R2: While uncalibrated and the line holds steady, the state does not change. The first clock edge that samples a change of `rxBit` starts a calibration window lasting exactly `CAL_CYCLES` clock cycles. During that window `txBit`=1 whatever `rxBit` does, and `calibrated`=0.
- R3: `calDone` is high for exactly one cycle, the last cycle of the calibration window. `calibrated` rises in the following cycle.
- R4: While calibrated and the input side is powered, `txBit` equals `rxBit` in the same cycle.
- R5: If `IDLE_CYCLES`+1 consecutive clock edges pass after the last sampled transition without a new one, `calibrated` falls and `txBit` returns high. The next transition starts a new calibration window.
- R6: `txDrive` (1 = drive, 0 = high impedance) equals `outEnable` in every cycle and in every state.
- R7: While `srcPowerGood`=0, `txBit`=1 in the same cycle and `calibrated` is 0 from the next cycle on. After power returns, the channel must pass a full calibration window before it follows the input again.
- R8: While calibrated, `runViolation` pulses high for one cycle, one cycle after the clock edge that samples the (`MAX_RUN`+1)-th equal bit in a row. A run of exactly `MAX_RUN` equal bits gives no pulse.
- R9: Transitions of `rxBit` while `srcPowerGood`=0 are ignored. The first cycle after power returns is not counted as a transition, so with a steady line the channel stays uncalibrated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxBit | input | 1 | Sampled incoming line bit |
| srcPowerGood | input | 1 | Input-side supply reported good |
| outEnable | input | 1 | Output enable, active high |
| txBit | output | 1 | Repeated data bit |
| txDrive | output | 1 | 1 = drive output, 0 = high impedance |
| calibrated | output | 1 | Channel calibrated and following the input |
| calDone | output | 1 | One-cycle pulse in the last calibration cycle |
| runViolation | output | 1 | One-cycle pulse on an over-long run while calibrated |

## Verification
The bench feeds several input patterns and checks that each one is told apart correctly:
- A line that toggles every cycle during calibration, which must never leak to `txBit`.
- A DC-balanced bit pattern that the calibrated output must copy.
- Runs of exactly `MAX_RUN` and `MAX_RUN`+1 equal bits, which separate a legal run from a violation.
- A line held quiet up to the idle limit and one cycle past it, which separates a long run from an idle timeout.
- Toggling while input power is down, which must not count as activity.
- A return of power with a steady line, which must still leave the channel uncalibrated.

// File: rtl/lcg_pkg.sv
package lcg_pkg;
  typedef enum logic [1:0] {
    LNK_UNCAL = 2'd0,
    LNK_CAL   = 2'd1,
    LNK_LIVE  = 2'd2
  } linkState_t;

  typedef struct packed {
    logic calClr;
    logic calRun;
    logic passThru;
  } dpStrobe_t;
endpackage

// File: rtl/lcg_datapath.sv
module lcg_datapath
  import lcg_pkg::*;
#(
  parameter int CAL_CYCLES  = 256,
  parameter int IDLE_CYCLES = 1024,
  parameter int MAX_RUN     = 6
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      rxBit,
  input  logic      srcPowerGood,
  input  logic      outEnable,
  input  dpStrobe_t strobe,
  output logic      edgeSeen,
  output logic      idleHit,
  output logic      calEnd,
  output logic      runOver,
  output logic      txBit,
  output logic      txDrive
);
  localparam int CAL_W  = (CAL_CYCLES > 1) ? $clog2(CAL_CYCLES) : 1;
  localparam int IDLE_W = $clog2(IDLE_CYCLES + 1);
  localparam int RUN_SAT = MAX_RUN + 2;
  localparam int RUN_W  = $clog2(RUN_SAT + 1);
  localparam logic [CAL_W-1:0]  CAL_LAST = CAL_W'(CAL_CYCLES - 1);
  localparam logic [IDLE_W-1:0] IDLE_LIM = IDLE_W'(IDLE_CYCLES);
  localparam logic [RUN_W-1:0]  RUN_TOP  = RUN_W'(RUN_SAT);
  localparam logic [RUN_W-1:0]  RUN_BAD  = RUN_W'(MAX_RUN + 1);

  logic              rxPrev;
  logic              prevValid;
  logic [CAL_W-1:0]  calCnt;
  logic [IDLE_W-1:0] idleCnt;
  logic [RUN_W-1:0]  runLen;

  // A transition only counts when both samples come from a powered input side.
  assign edgeSeen = prevValid & srcPowerGood & (rxBit != rxPrev);

  always_ff @(posedge clk) begin
    if (rst) begin
      rxPrev    <= 1'b0;
      prevValid <= 1'b0;
    end else begin
      rxPrev    <= rxBit;
      prevValid <= srcPowerGood;
    end
  end

  // Cycles since the last accepted transition, saturating at the limit.
  always_ff @(posedge clk) begin
    if (rst || edgeSeen)
      idleCnt <= '0;
    else if (idleCnt != IDLE_LIM)
      idleCnt <= idleCnt + 1'b1;
  end
  assign idleHit = (idleCnt == IDLE_LIM);

  // Length of the run ending at the last sampled bit.
  always_ff @(posedge clk) begin
    if (rst || edgeSeen || !prevValid)
      runLen <= RUN_W'(1);
    else if (runLen != RUN_TOP)
      runLen <= runLen + 1'b1;
  end
  assign runOver = (runLen == RUN_BAD);

  // Calibration window timer.
  always_ff @(posedge clk) begin
    if (rst || strobe.calClr)
      calCnt <= '0;
    else if (strobe.calRun && calCnt != CAL_LAST)
      calCnt <= calCnt + 1'b1;
  end
  assign calEnd = strobe.calRun && (calCnt == CAL_LAST);

  // Output gating: default high unless live and powered.
  assign txBit   = (strobe.passThru && srcPowerGood) ? rxBit : 1'b1;
  assign txDrive = outEnable;
endmodule

// File: rtl/lcg_control.sv
module lcg_control
  import lcg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      srcPowerGood,
  input  logic      edgeSeen,
  input  logic      idleHit,
  input  logic      calEnd,
  input  logic      runOver,
  output dpStrobe_t strobe,
  output logic      calibrated,
  output logic      calDone,
  output logic      runViolation
);
  linkState_t state, stateNext;

  always_comb begin
    stateNext = state;
    if (!srcPowerGood) begin
      stateNext = LNK_UNCAL;
    end else begin
      unique case (state)
        LNK_UNCAL: if (edgeSeen) stateNext = LNK_CAL;
        LNK_CAL:   if (calEnd)   stateNext = LNK_LIVE;
        LNK_LIVE:  if (idleHit)  stateNext = LNK_UNCAL;
        default:                 stateNext = LNK_UNCAL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= LNK_UNCAL;
    else     state <= stateNext;
  end

  always_comb begin
    strobe.calClr   = (state != LNK_CAL);
    strobe.calRun   = (state == LNK_CAL);
    strobe.passThru = (state == LNK_LIVE);
  end

  assign calibrated   = (state == LNK_LIVE);
  assign calDone      = (state == LNK_CAL) && calEnd && srcPowerGood;
  assign runViolation = (state == LNK_LIVE) && runOver;
endmodule

// File: rtl/link_cal_gate.sv
module link_cal_gate
  import lcg_pkg::*;
#(
  parameter int CAL_CYCLES  = 256,
  parameter int IDLE_CYCLES = 1024,
  parameter int MAX_RUN     = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic rxBit,
  input  logic srcPowerGood,
  input  logic outEnable,
  output logic txBit,
  output logic txDrive,
  output logic calibrated,
  output logic calDone,
  output logic runViolation
);
  dpStrobe_t strobe;
  logic edgeSeen, idleHit, calEnd, runOver;

  lcg_datapath #(
    .CAL_CYCLES (CAL_CYCLES),
    .IDLE_CYCLES(IDLE_CYCLES),
    .MAX_RUN    (MAX_RUN)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .rxBit       (rxBit),
    .srcPowerGood(srcPowerGood),
    .outEnable   (outEnable),
    .strobe      (strobe),
    .edgeSeen    (edgeSeen),
    .idleHit     (idleHit),
    .calEnd      (calEnd),
    .runOver     (runOver),
    .txBit       (txBit),
    .txDrive     (txDrive)
  );

  lcg_control u_ctl (
    .clk         (clk),
    .rst         (rst),
    .srcPowerGood(srcPowerGood),
    .edgeSeen    (edgeSeen),
    .idleHit     (idleHit),
    .calEnd      (calEnd),
    .runOver     (runOver),
    .strobe      (strobe),
    .calibrated  (calibrated),
    .calDone     (calDone),
    .runViolation(runViolation)
  );
endmodule

// File: rtl/lcg_checker.sv
module lcg_checker (
  input logic clk,
  input logic rst,
  input logic rxBit,
  input logic srcPowerGood,
  input logic outEnable,
  input logic txBit,
  input logic txDrive,
  input logic calibrated,
  input logic calDone,
  input logic runViolation
);
  a_r2_uncal_high: assert property (@(posedge clk) disable iff (rst)
    !calibrated |-> txBit);
  a_r3_done_then_live: assert property (@(posedge clk) disable iff (rst)
    calDone |=> calibrated);
  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    calDone |=> !calDone);
  a_r3_live_after_done: assert property (@(posedge clk) disable iff (rst)
    $rose(calibrated) |-> $past(calDone));
  a_r4_follow: assert property (@(posedge clk) disable iff (rst)
    (calibrated && srcPowerGood) |-> (txBit == rxBit));
  a_r6_drive: assert property (@(posedge clk) disable iff (rst)
    txDrive == outEnable);
  a_r7_pwr_high: assert property (@(posedge clk) disable iff (rst)
    !srcPowerGood |-> txBit);
  a_r7_pwr_uncal: assert property (@(posedge clk) disable iff (rst)
    !srcPowerGood |=> !calibrated);
  a_r8_viol_live: assert property (@(posedge clk) disable iff (rst)
    runViolation |-> calibrated);
  a_r8_viol_single: assert property (@(posedge clk) disable iff (rst)
    runViolation |=> !runViolation);
endmodule

bind link_cal_gate lcg_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .rxBit       (rxBit),
  .srcPowerGood(srcPowerGood),
  .outEnable   (outEnable),
  .txBit       (txBit),
  .txDrive     (txDrive),
  .calibrated  (calibrated),
  .calDone     (calDone),
  .runViolation(runViolation)
);

// File: tb/sim_link_cal_gate.sv
`timescale 1ns/1ps
module sim_link_cal_gate;
  localparam int CAL  = 16;
  localparam int IDLE = 40;
  localparam int RUN  = 6;

  logic clk = 1'b0;
  logic rst, rxBit, srcPowerGood, outEnable;
  logic txBit, txDrive, calibrated, calDone, runViolation;
  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  link_cal_gate #(.CAL_CYCLES(CAL), .IDLE_CYCLES(IDLE), .MAX_RUN(RUN)) u0 (
    .clk(clk), .rst(rst), .rxBit(rxBit), .srcPowerGood(srcPowerGood),
    .outEnable(outEnable), .txBit(txBit), .txDrive(txDrive),
    .calibrated(calibrated), .calDone(calDone), .runViolation(runViolation)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  // R1 reset state, R2 steady line keeps channel uncalibrated
  task automatic testReset();
    rst = 1'b1; rxBit = 1'b0; srcPowerGood = 1'b1; outEnable = 1'b1;
    tick(); tick();
    chk("R1 txBit", txBit, 1'b1);
    chk("R1 calibrated", calibrated, 1'b0);
    chk("R1 calDone", calDone, 1'b0);
    chk("R1 runViolation", runViolation, 1'b0);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R2 steady stays uncal", calibrated, 1'b0);
    end
  endtask

  // R2/R3: toggle every cycle through the window; output stays high
  task automatic bringUp(input string why);
    for (int i = 1; i <= CAL; i++) begin
      rxBit = ~rxBit;
      tick();
      chk({"R2 in window ", why}, calibrated, 1'b0);
      chk("R2 window forces high", txBit, 1'b1);
      chk("R3 calDone timing", calDone, (i == CAL));
    end
    tick();
    chk({"R3 calibrated after done ", why}, calibrated, 1'b1);
    chk("R3 calDone single", calDone, 1'b0);
  endtask

  // R4: balanced pattern copied in the same cycle
  task automatic testFollow();
    logic [15:0] pat = 16'b1100_1010_0111_0001;
    for (int i = 0; i < 16; i++) begin
      rxBit = pat[i];
      #1;
      chk("R4 follow", txBit, pat[i]);
      tick();
    end
    chk("R4 still calibrated", calibrated, 1'b1);
  endtask

  // R8: run of RUN is legal, RUN+1 pulses once
  task automatic testRuns();
    rxBit = ~rxBit; tick();
    for (int i = 2; i <= RUN; i++) begin
      tick();
      chk("R8 no pulse within limit", runViolation, 1'b0);
    end
    rxBit = ~rxBit; tick();
    for (int i = 2; i <= RUN; i++) begin
      tick();
      chk("R8 no early pulse", runViolation, 1'b0);
    end
    tick();
    chk("R8 pulse on long run", runViolation, 1'b1);
    tick();
    chk("R8 pulse single", runViolation, 1'b0);
    rxBit = ~rxBit; tick();
  endtask

  // R5: idle timeout drops calibration, next edge recalibrates
  task automatic testIdle();
    rxBit = 1'b1; tick();
    rxBit = 1'b0; tick();
    for (int i = 0; i < IDLE; i++) tick();
    chk("R5 still live at limit", calibrated, 1'b1);
    chk("R5 follows low at limit", txBit, 1'b0);
    tick();
    chk("R5 uncal after timeout", calibrated, 1'b0);
    chk("R5 output high after timeout", txBit, 1'b1);
    bringUp("after idle R5");
  endtask

  // R6: enable controls drive flag in live and uncal states
  task automatic testEnable();
    outEnable = 1'b0; #1;
    chk("R6 disabled", txDrive, 1'b0);
    outEnable = 1'b1; #1;
    chk("R6 enabled", txDrive, 1'b1);
  endtask

  // R7/R9: power loss, ignored toggles, recalibration
  task automatic testPower();
    rxBit = 1'b0; tick();
    srcPowerGood = 1'b0; #1;
    chk("R7 default high", txBit, 1'b1);
    tick();
    chk("R7 uncal on power loss", calibrated, 1'b0);
    for (int i = 0; i < 5; i++) begin
      rxBit = ~rxBit; tick();
      chk("R9 toggles ignored", calibrated, 1'b0);
      chk("R9 no calDone", calDone, 1'b0);
    end
    srcPowerGood = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R9 return not an edge", calibrated, 1'b0);
      chk("R7 high until recal", txBit, 1'b1);
    end
    outEnable = 1'b0; #1;
    chk("R6 disabled while uncal", txDrive, 1'b0);
    outEnable = 1'b1;
    bringUp("after power R7");
  endtask

  initial begin
    testReset();
    bringUp("first R2");
    testEnable();
    testFollow();
    testRuns();
    testIdle();
    testPower();
    testFollow();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule